// File: doc/BRIEF.md
# Shared Memory Window Bus Controller

This block is the glue between one host processor bus and two satellite processors. Each satellite owns a private 64 KB memory. The same memory also appears to the host as a window at a fixed physical range. Satellite 0's window sits at D0000h–DFFFFh and satellite 1's at E0000h–EFFFFh. The host and the satellite see every location at the same address. The block decodes host memory cycles into window chip selects. It enables the isolation buffers for a window only while a host cycle selects it. Because the host bus carries no direction signal, the buffer direction is taken from the read and write strobes.

A host-written control word decides two things for each satellite: whether the satellite is isolated from its window, and whether it is held in reset or allowed to run. A host access to a window is blocked when the satellite behind it is running and not isolated. The block does not drive the chip select for such an access, and it sets a contention flag instead. The block also watches each satellite's three status lines. When a satellite reports the halt code, the block latches one interrupt request to the host for that satellite.

Top module: `win_bus_ctrl`

## Requirements
- R1: A host cycle with exactly one of `host_memr`/`host_memw` high asserts `win_cs[0]` when `host_addr[19:16]` is 4'hD, or `win_cs[1]` when it is 4'hE. This happens in the same cycle, provided the access is allowed (see R7).
- R2: `win_cs` stays low in these cases: neither strobe is high, both strobes are high, or the address lies outside both windows.
- R3: `buf_en[i]` is high only while `win_cs[i]` is high. `buf_dir` is 1 during a selected write and 0 during a selected read. `buf_dir` is 0 when no window is selected.
- R4: In the control word written with `ctrl_we`, bit i is satellite i's isolation bit and bit 2+i is its run bit. After the write edge, `sat_reset_n[i]` equals the run bit, where 0 holds the satellite in reset.
- R5: After system reset, `sat_reset_n`, `win_cs`, `buf_en`, `irq` and `contention_err` are all zero.
- R6: An access to window i is blocked when satellite i is running (run bit 1) and not isolated (isolation bit 0). A blocked access leaves `win_cs[i]` low and sets `contention_err[i]` after the next clock edge. The flag then holds until an acknowledge write.
- R7: An access is allowed when the satellite is held in reset or its isolation bit is set.
- R8: Status code 3'b011 on `sat_status[3i+2:3i]` is the halt code. When a running satellite's status enters the halt code, `irq[i]` rises after the next clock edge. No other status code raises it.
- R9: A single halt produces one request. `irq[i]` stays high until an acknowledge write (control bit 4+i = 1), which clears it after the write edge. It does not rise again while the status stays at the halt code.
- R10: Holding a satellite in reset (run bit 0) clears its `irq` after the second clock edge and keeps it low. An acknowledge write also clears `contention_err[i]`.
- R11: If a new halt edge and an acknowledge arrive in the same cycle, `irq[i]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| host_addr | input | 20 | Host physical address |
| host_memr | input | 1 | Host memory read strobe, active high |
| host_memw | input | 1 | Host memory write strobe, active high |
| ctrl_we | input | 1 | Host write to the control port |
| ctrl_wdata | input | 8 | Control word: isolation [1:0], run [3:2], acknowledge [5:4] |
| sat_status | input | 6 | Satellite status lines, 3 per satellite |
| win_cs | output | 2 | Window memory chip selects |
| buf_en | output | 2 | Isolation buffer enables |
| buf_dir | output | 1 | Buffer direction, 1 = host to memory |
| sat_reset_n | output | 2 | Satellite reset lines, 0 holds in reset |
| irq | output | 2 | Halt interrupt requests to the host |
| contention_err | output | 2 | Blocked-access flags |

## Verification
The bench drives random addresses biased toward both windows. It mixes in reads, writes, idle cycles and double strobes, under random control words. A decoder that ignored the double-strobe case or the ownership check would raise a chip select while the satellite also drives the bus. A wrong direction term would make the buffers fight the memory on reads. Directed sequences cover the interrupt corners: every non-halt status code, a status that stays halted after an acknowledge, a halt edge in the same cycle as an acknowledge, and reset clearing a pending request. A level-triggered or unlatched interrupt would either repeat requests or lose them.

// File: rtl/win_pkg.sv
package win_pkg;
    localparam logic [2:0] HALT_CODE = 3'b011;
    localparam int STATUS_W = 3;
endpackage

// File: rtl/win_decode.sv
module win_decode #(
    parameter int AW    = 20,
    parameter int TAG_W = 4,
    parameter logic [TAG_W-1:0] TAG = 4'hD
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    assign hit = (addr[AW-1 -: TAG_W] == TAG);
endmodule

// File: rtl/halt_detect.sv
module halt_detect
    import win_pkg::*;
(
    input  logic [STATUS_W-1:0] status,
    output logic                halted
);
    assign halted = (status == HALT_CODE);
endmodule

// File: rtl/win_bus_ctrl.sv
module win_bus_ctrl
    import win_pkg::*;
#(
    parameter int NSAT   = 2,
    parameter int AW     = 20,
    parameter int TAG_W  = 4,
    parameter logic [TAG_W-1:0] BASE_TAG = 4'hD,
    parameter int CW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            host_addr,
    input  logic                     host_memr,
    input  logic                     host_memw,
    input  logic                     ctrl_we,
    input  logic [CW-1:0]            ctrl_wdata,
    input  logic [NSAT*STATUS_W-1:0] sat_status,
    output logic [NSAT-1:0]          win_cs,
    output logic [NSAT-1:0]          buf_en,
    output logic                     buf_dir,
    output logic [NSAT-1:0]          sat_reset_n,
    output logic [NSAT-1:0]          irq,
    output logic [NSAT-1:0]          contention_err
);
    localparam int ISO_OFS = 0;
    localparam int RUN_OFS = NSAT;
    localparam int ACK_OFS = 2 * NSAT;

    typedef struct packed {
        logic [NSAT-1:0] iso;
        logic [NSAT-1:0] run;
        logic [NSAT-1:0] halt;
        logic [NSAT-1:0] irq;
        logic [NSAT-1:0] err;
    } state_t;

    state_t          st_d, st_q;
    logic [NSAT-1:0] hit, halt_vec, blocked, ack, iso_q;
    logic            strobe;

    generate
        for (genvar g = 0; g < NSAT; g++) begin : g_sat
            win_decode #(
                .AW(AW), .TAG_W(TAG_W),
                .TAG(BASE_TAG + TAG_W'(g))
            ) u_dec (
                .addr(host_addr),
                .hit (hit[g])
            );
            halt_detect u_halt (
                .status(sat_status[g*STATUS_W +: STATUS_W]),
                .halted(halt_vec[g])
            );
        end
    endgenerate

    // Bus side: ownership gate on the decoded window hit
    always_comb begin
        strobe = host_memr ^ host_memw;
        for (int i = 0; i < NSAT; i++) begin
            win_cs[i]  = strobe & hit[i] & (st_q.iso[i] | ~st_q.run[i]);
            blocked[i] = strobe & hit[i] & st_q.run[i] & ~st_q.iso[i];
        end
        buf_en  = win_cs;
        buf_dir = host_memw & (|win_cs);
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        ack  = ctrl_we ? ctrl_wdata[ACK_OFS +: NSAT] : '0;
        if (ctrl_we) begin
            st_d.iso = ctrl_wdata[ISO_OFS +: NSAT];
            st_d.run = ctrl_wdata[RUN_OFS +: NSAT];
        end
        st_d.halt = halt_vec;
        for (int i = 0; i < NSAT; i++) begin
            if (st_q.run[i])
                st_d.irq[i] = (st_q.irq[i] & ~ack[i])
                            | (halt_vec[i] & ~st_q.halt[i]);
            else
                st_d.irq[i] = 1'b0;
            st_d.err[i] = (st_q.err[i] & ~ack[i]) | blocked[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iso_q          = st_q.iso;
    assign sat_reset_n    = st_q.run;
    assign irq            = st_q.irq;
    assign contention_err = st_q.err;
endmodule

// File: rtl/win_bus_ctrl_sva.sv
module win_bus_ctrl_sva #(
    parameter int NSAT = 2,
    parameter int AW   = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       host_addr,
    input logic                host_memr,
    input logic                host_memw,
    input logic [NSAT*3-1:0]   sat_status,
    input logic [NSAT-1:0]     win_cs,
    input logic [NSAT-1:0]     buf_en,
    input logic                buf_dir,
    input logic [NSAT-1:0]     sat_reset_n,
    input logic [NSAT-1:0]     irq,
    input logic [NSAT-1:0]     iso_q
);
    assert_one_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_cs));

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_en && host_memw) |-> buf_dir);

    assert_dir_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_en && host_memr) |-> !buf_dir);

    generate
        for (genvar g = 0; g < NSAT; g++) begin : g_chk
            assert_buf_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
                buf_en[g] |-> (host_memr ^ host_memw));

            assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
                win_cs[g] |-> (!sat_reset_n[g] || iso_q[g]));

            assert_irq_from_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq[g]) |-> $past(sat_status[g*3 +: 3] == 3'b011));

            assert_reset_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (!sat_reset_n[g] && $past(!sat_reset_n[g])) |-> !irq[g]);
        end
    endgenerate
endmodule

bind win_bus_ctrl win_bus_ctrl_sva #(.NSAT(NSAT), .AW(AW)) u_sva (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .host_memr(host_memr), .host_memw(host_memw), .sat_status(sat_status),
    .win_cs(win_cs), .buf_en(buf_en), .buf_dir(buf_dir),
    .sat_reset_n(sat_reset_n), .irq(irq), .iso_q(iso_q)
);

// File: tb/win_bus_ctrl_tb.sv
module win_bus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic        host_memr = 1'b0, host_memw = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [5:0]  sat_status = '0;
    logic [1:0]  win_cs, buf_en, sat_reset_n, irq, contention_err;
    logic        buf_dir;

    int n_chk = 0, n_bad = 0;
    logic [1:0] m_iso = '0, m_run = '0, m_err = '0;

    always #10 clk = ~clk;

    win_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_memr(host_memr), .host_memw(host_memw),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .sat_status(sat_status),
        .win_cs(win_cs), .buf_en(buf_en), .buf_dir(buf_dir),
        .sat_reset_n(sat_reset_n), .irq(irq), .contention_err(contention_err)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic exp_hit(input int i, input logic [19:0] a);
        return a[19:16] == (4'hD + 4'(i));
    endfunction

    function automatic logic exp_cs(input int i, input logic [19:0] a, input logic r, input logic w);
        return (r ^ w) & exp_hit(i, a) & (m_iso[i] | ~m_run[i]);
    endfunction

    function automatic logic exp_block(input int i, input logic [19:0] a, input logic r, input logic w);
        return (r ^ w) & exp_hit(i, a) & m_run[i] & ~m_iso[i];
    endfunction

    task automatic wr_ctrl(input logic [1:0] iso, input logic [1:0] run, input logic [1:0] ack);
        ctrl_we    = 1'b1;
        ctrl_wdata = {2'b00, ack, run, iso};
        @(posedge clk); #1;
        ctrl_we = 1'b0;
        m_iso = iso; m_run = run; m_err = m_err & ~ack;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R5 reset state
        chk("R5 sat_reset_n", 8'(sat_reset_n), 8'h0);
        chk("R5 irq", 8'(irq), 8'h0);
        chk("R5 err", 8'(contention_err), 8'h0);
        host_addr = 20'hD1234; host_memr = 1'b1; #2;
        chk("R7 cs in reset", 8'(win_cs), 8'h1);
        chk("R3 dir read", 8'(buf_dir), 8'h0);
        host_memr = 1'b0; host_memw = 1'b1; #2;
        chk("R3 dir write", 8'(buf_dir), 8'h1);
        chk("R3 buf_en", 8'(buf_en), 8'h1);
        host_memr = 1'b1; #2;
        chk("R2 both strobes", 8'(win_cs), 8'h0);
        host_memr = 1'b0; host_memw = 1'b0; #2;
        chk("R3 dir idle", 8'(buf_dir), 8'h0);

        // R4 control layout
        wr_ctrl(2'b10, 2'b01, 2'b00);
        chk("R4 reset lines", 8'(sat_reset_n), 8'h1);

        // Random access mix against model (R1 R2 R3 R6 R7)
        for (int it = 0; it < 400; it++) begin
            logic [1:0] sel;
            if (($urandom % 4) == 0)
                wr_ctrl(2'($urandom), 2'($urandom), 2'($urandom));
            sel = 2'($urandom % 3);
            host_addr = 20'($urandom);
            if (sel == 0) host_addr[19:16] = 4'hD;
            if (sel == 1) host_addr[19:16] = 4'hE;
            {host_memr, host_memw} = 2'($urandom);
            #2;
            for (int i = 0; i < 2; i++) begin
                chk("R1 R6 R7 win_cs", 8'(win_cs[i]), 8'(exp_cs(i, host_addr, host_memr, host_memw)));
                chk("R3 buf_en", 8'(buf_en[i]), 8'(exp_cs(i, host_addr, host_memr, host_memw)));
                m_err[i] = m_err[i] | exp_block(i, host_addr, host_memr, host_memw);
            end
            chk("R3 buf_dir", 8'(buf_dir),
                8'(host_memw & (exp_cs(0, host_addr, host_memr, host_memw) |
                                exp_cs(1, host_addr, host_memr, host_memw))));
            tick();
            chk("R6 R10 contention_err", 8'(contention_err), 8'(m_err));
            host_memr = 1'b0; host_memw = 1'b0;
        end

        // Interrupt corners
        wr_ctrl(2'b11, 2'b11, 2'b11);
        sat_status = 6'o00; tick(); tick();
        chk("R8 no irq idle", 8'(irq), 8'h0);
        sat_status[2:0] = 3'b011; tick();
        chk("R8 halt raises irq", 8'(irq), 8'h1);
        repeat (3) tick();
        chk("R9 irq held", 8'(irq), 8'h1);
        wr_ctrl(2'b11, 2'b11, 2'b01);
        chk("R9 ack clears", 8'(irq), 8'h0);
        repeat (3) tick();
        chk("R9 no repeat while halted", 8'(irq), 8'h0);
        for (int c = 0; c < 8; c++) begin
            if (c != 3) begin
                sat_status[5:3] = 3'b000; tick();
                sat_status[5:3] = 3'(c); tick(); tick();
                chk("R8 non-halt code", 8'(irq[1]), 8'h0);
            end
        end
        sat_status[2:0] = 3'b000; tick();
        sat_status[2:0] = 3'b011;
        ctrl_we = 1'b1; ctrl_wdata = 8'b0001_1111;
        tick();
        ctrl_we = 1'b0;
        chk("R11 edge beats ack", 8'(irq[0]), 8'h1);
        wr_ctrl(2'b11, 2'b10, 2'b00);
        tick();
        chk("R10 reset clears irq", 8'(irq[0]), 8'h0);
        chk("R4 reset line low", 8'(sat_reset_n), 8'h2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule